// File: doc/BRIEF.md
# Signed Integer to Extended-Float Register-Stack Loader

This block accepts a signed two's-complement integer of 16, 32 or 64 bits, turns it into an 80-bit double-extended floating-point value, and pushes that value onto an eight-entry circular register stack. The conversion needs no rounding, because every integer of these widths fits in the 64-bit significand. Each stack register carries an empty/valid tag. A push first moves the top pointer down by one and then writes the converted value into the register that is now on top.

A request is one cycle of `op_valid`, with the opcode byte, the ModRM reg field and the operand on `op_data`. The opcode byte and the reg field together choose the source width. Any other combination is treated as not addressed to this block. The stack can be read at any time, relative to the current top, through `rd_idx`.

When the register below the top is already tagged valid, the push is refused. In that case a one-cycle fault pulse replaces the done pulse, and the stack does not change.

Top module: `ixp_loader`

## Requirements
- R1: The source width is decoded as follows. Byte 8'hDF with reg 0 selects 16 bits and uses `op_data[15:0]`. Byte 8'hDB with reg 0 selects 32 bits and uses `op_data[31:0]`. Byte 8'hDF with reg 5 selects 64 bits. Operand bits above the selected width have no effect.
- R2: A valid request with any other byte/reg pair is ignored. No done or fault pulse follows, and the top pointer and register contents stay as they were.
- R3: The operand is sign-extended from its width. Bit 79 of the result is the operand's sign.
- R4: Result layout is bit 79 for the sign, bits 78:64 for the exponent biased by 16383, and bits 63:0 for the significand with an explicit integer bit. A nonzero magnitude m is shifted left by s until bit 63 is set, and the exponent is 16383+63-s. The value is exact.
- R5: An integer zero yields the all-zero 80-bit word, with a positive sign.
- R6: The 64-bit value 8000_0000_0000_0000h yields sign 1, exponent 16446 and significand 8000_0000_0000_0000h, that is 80'hC03E_8000_0000_0000_0000.
- R7: A successful push sets the top pointer to (top-1) mod 8 and writes the value there. `st_value` shows the register at (top + `rd_idx`) mod 8.
- R8: A successful push tags its target register valid. `st_valid` gives the tag of the register selected by `rd_idx`.
- R9: A push is refused when the register at (top-1) mod 8 is tagged valid. In that case `stack_fault` pulses for one cycle, and the top pointer, tags and values stay unchanged.
- R10: `done` is high for exactly the one cycle after the accepting edge. `done` and `stack_fault` are never high together.
- R11: After reset the top pointer is 0, every tag is empty, and `done` and `stack_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe, one cycle per request |
| op_byte | input | 8 | Opcode byte |
| op_reg | input | 3 | ModRM reg field |
| op_data | input | 64 | Integer operand, low-aligned |
| rd_idx | input | 3 | Read offset from the stack top |
| done | output | 1 | Push completed (one-cycle pulse) |
| stack_fault | output | 1 | Push refused, stack full (one-cycle pulse) |
| top_ptr | output | 3 | Current top-of-stack pointer |
| st_value | output | 80 | Register at (top + rd_idx) mod 8 |
| st_valid | output | 1 | Tag of that register |

## Verification
The overflow lookup for one push and the tag update from the push just before it can fall in adjacent edges with no gap between them. The bench provokes this by holding requests back to back: the eighth push fills the last free register, and the ninth arrives in the very next cycle. The ninth push must see the fresh tag and produce a fault rather than a second done. The scoreboard judges this by the kind of each pulse, and by a top pointer and top value that stay unchanged after the refused push.

// File: rtl/ixp_pkg.sv
package ixp_pkg;

  localparam int EXT_W    = 80;
  localparam int EXP_W    = 15;
  localparam int SIG_W    = 64;
  localparam int EXP_BIAS = 16383;

  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_16   = 2'd1,
    W_32   = 2'd2,
    W_64   = 2'd3
  } src_width_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } ext80_t;

  // Number of zero bits above the most significant one; 64 for zero.
  function automatic logic [6:0] lead_zeros(input logic [SIG_W-1:0] mag);
    logic [6:0] n;
    n = 7'd64;
    for (int i = 0; i < SIG_W; i++) begin
      if (mag[i]) n = 7'(SIG_W - 1 - i);
    end
    return n;
  endfunction

  // Exact conversion of a 64-bit signed value into the extended format.
  function automatic ext80_t to_ext80(input logic [SIG_W-1:0] sval);
    ext80_t           r;
    logic             neg;
    logic [SIG_W-1:0] mag;
    logic [6:0]       lz;
    neg = sval[SIG_W-1];
    mag = neg ? (~sval + 1'b1) : sval;
    lz  = lead_zeros(mag);
    if (mag == '0) begin
      r = '0;
    end else begin
      r.sign = neg;
      r.exp  = EXP_W'(EXP_BIAS + SIG_W - 1) - EXP_W'(lz);
      r.sig  = mag << lz;
    end
    return r;
  endfunction

endpackage

// File: rtl/ixp_width_dec.sv
module ixp_width_dec
  import ixp_pkg::*;
#(
  parameter logic [7:0] OPC_WORD_QUAD = 8'hDF,
  parameter logic [7:0] OPC_DWORD     = 8'hDB,
  parameter logic [2:0] REG_SHORT     = 3'd0,
  parameter logic [2:0] REG_QUAD      = 3'd5
) (
  input  logic [7:0] op_byte,
  input  logic [2:0] op_reg,
  output src_width_e wsel
);

  always_comb begin
    wsel = W_NONE;
    if (op_byte == OPC_WORD_QUAD && op_reg == REG_SHORT) wsel = W_16;
    else if (op_byte == OPC_DWORD && op_reg == REG_SHORT) wsel = W_32;
    else if (op_byte == OPC_WORD_QUAD && op_reg == REG_QUAD) wsel = W_64;
  end

endmodule

// File: rtl/ixp_normalize.sv
module ixp_normalize
  import ixp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  src_width_e        wsel,
  input  logic [DATA_W-1:0] raw,
  output ext80_t            result
);

  logic [DATA_W-1:0] sx;

  always_comb begin
    case (wsel)
      W_16:    sx = {{(DATA_W-16){raw[15]}}, raw[15:0]};
      W_32:    sx = {{(DATA_W-32){raw[31]}}, raw[31:0]};
      default: sx = raw;
    endcase
  end

  assign result = to_ext80(sx);

endmodule

// File: rtl/ixp_stack.sv
module ixp_stack
  import ixp_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  ext80_t           push_val,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [PTR_W-1:0] top_ptr,
  output ext80_t           rd_val,
  output logic             rd_tag,
  output logic             push_ok,
  output logic             push_ovf
);

  logic [PTR_W-1:0] top_q;
  logic [PTR_W-1:0] next_idx;
  logic [PTR_W-1:0] rd_slot;
  logic [DEPTH-1:0] tag_vec;
  ext80_t           val_vec [DEPTH];

  assign next_idx = top_q - 1'b1;
  assign push_ovf = push_req &&  tag_vec[next_idx];
  assign push_ok  = push_req && !tag_vec[next_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)       top_q <= '0;
    else if (push_ok) top_q <= next_idx;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic   slot_tag;
    ext80_t slot_val;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_tag <= 1'b0;
        slot_val <= '0;
      end else if (push_ok && next_idx == PTR_W'(g)) begin
        slot_tag <= 1'b1;
        slot_val <= push_val;
      end
    end
    assign tag_vec[g] = slot_tag;
    assign val_vec[g] = slot_val;
  end

  assign rd_slot = top_q + rd_idx;
  assign rd_val  = val_vec[rd_slot];
  assign rd_tag  = tag_vec[rd_slot];
  assign top_ptr = top_q;

endmodule

// File: rtl/ixp_loader.sv
module ixp_loader
  import ixp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        op_byte,
  input  logic [2:0]        op_reg,
  input  logic [DATA_W-1:0] op_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic              done,
  output logic              stack_fault,
  output logic [PTR_W-1:0]  top_ptr,
  output logic [EXT_W-1:0]  st_value,
  output logic              st_valid
);

  src_width_e       wsel;
  ext80_t           cvt;
  ext80_t           rd_val;
  logic             acc_fire;
  logic             push_hit;
  logic             ovf_hit;
  logic [EXT_W-1:0] cvt_word;
  logic             done_q;
  logic             fault_q;

  ixp_width_dec u_dec (
    .op_byte (op_byte),
    .op_reg  (op_reg),
    .wsel    (wsel)
  );

  ixp_normalize #(.DATA_W(DATA_W)) u_norm (
    .wsel   (wsel),
    .raw    (op_data),
    .result (cvt)
  );

  assign acc_fire = op_valid && (wsel != W_NONE);
  assign cvt_word = cvt;

  ixp_stack #(.DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (acc_fire),
    .push_val (cvt),
    .rd_idx   (rd_idx),
    .top_ptr  (top_ptr),
    .rd_val   (rd_val),
    .rd_tag   (st_valid),
    .push_ok  (push_hit),
    .push_ovf (ovf_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= push_hit;
      fault_q <= ovf_hit;
    end
  end

  assign done        = done_q;
  assign stack_fault = fault_q;
  assign st_value    = rd_val;

endmodule

// File: rtl/ixp_loader_chk.sv
module ixp_loader_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             stack_fault,
  input logic [PTR_W-1:0] top_ptr,
  input logic [PTR_W-1:0] rd_idx,
  input logic             st_valid,
  input logic             acc_fire,
  input logic             ovf_hit,
  input logic [79:0]      cvt_word
);

  // R10
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && stack_fault));

  // R7
  top_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> top_ptr == PTR_W'($past(top_ptr) - 1'b1));

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |-> $stable(top_ptr));

  // R9
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (stack_fault && !done));

  // R8
  tag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rd_idx == '0) |-> st_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> (!done && !stack_fault));

  // R4
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_word[78:64] != 15'd0) |-> cvt_word[63]);

  // R5
  zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cvt_word[78:64] == 15'd0) |-> (cvt_word == 80'd0));

endmodule

bind ixp_loader ixp_loader_chk #(.PTR_W(PTR_W)) u_ixp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .stack_fault (stack_fault),
  .top_ptr     (top_ptr),
  .rd_idx      (rd_idx),
  .st_valid    (st_valid),
  .acc_fire    (acc_fire),
  .ovf_hit     (ovf_hit),
  .cvt_word    (cvt_word)
);

// File: tb/ixp_loader_bench.sv
`timescale 1ns/1ps
module ixp_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_byte = 8'h00;
  logic [2:0]  op_reg = 3'd0;
  logic [63:0] op_data = '0;
  logic [2:0]  rd_idx = 3'd0;
  logic        done;
  logic        stack_fault;
  logic [2:0]  top_ptr;
  logic [79:0] st_value;
  logic        st_valid;

  always #2.5 clk = ~clk;

  ixp_loader u_ixp_loader (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .op_reg(op_reg), .op_data(op_data), .rd_idx(rd_idx), .done(done),
    .stack_fault(stack_fault), .top_ptr(top_ptr), .st_value(st_value),
    .st_valid(st_valid)
  );

  typedef struct {
    logic        is_fault;
    logic [79:0] val;
    logic [2:0]  top;
    string       req;
  } exp_item_t;

  exp_item_t   sb_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [2:0]  m_top;
  logic [7:0]  m_tag;
  logic [79:0] m_val [8];

  task automatic chk(input logic ok, input string req, input logic [79:0] act,
                     input logic [79:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  // Reference: shift left one bit at a time until the integer bit is set.
  function automatic logic [79:0] ref_cvt(input int w, input logic [63:0] d);
    logic [63:0] v;
    logic        s;
    int          e;
    case (w)
      1:       v = 64'($signed(d[15:0]));
      2:       v = 64'($signed(d[31:0]));
      default: v = d;
    endcase
    s = v[63];
    if (s) v = 64'd0 - v;
    if (v == 64'd0) return 80'd0;
    e = 16383 + 63;
    while (!v[63]) begin
      v = v << 1;
      e = e - 1;
    end
    return {s, 15'(e), v};
  endfunction

  task automatic model_reset();
    m_top = 3'd0;
    m_tag = 8'h00;
    for (int i = 0; i < 8; i++) m_val[i] = 80'd0;
  endtask

  task automatic send(input logic [7:0] b, input logic [2:0] r,
                      input logic [63:0] d, input string req);
    int         w;
    logic [2:0] nt;
    exp_item_t  it;
    @(negedge clk);
    op_valid = 1'b1; op_byte = b; op_reg = r; op_data = d;
    w = (b == 8'hDF && r == 3'd0) ? 1 :
        (b == 8'hDB && r == 3'd0) ? 2 :
        (b == 8'hDF && r == 3'd5) ? 3 : 0;
    if (w != 0) begin
      nt = m_top - 3'd1;
      it.req = req;
      if (m_tag[nt]) begin
        it.is_fault = 1'b1; it.val = m_val[m_top]; it.top = m_top;
      end else begin
        it.is_fault = 1'b0; it.val = ref_cvt(w, d); it.top = nt;
        m_top = nt; m_tag[nt] = 1'b1; m_val[nt] = it.val;
      end
      sb_q.push_back(it);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  // Monitor: pops one expectation per result pulse.
  initial begin
    exp_item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && (done || stack_fault)) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R2 unexpected pulse", {78'd0, done, stack_fault}, 80'd0);
        end else begin
          it = sb_q.pop_front();
          chk(done == !it.is_fault && stack_fault == it.is_fault,
              {it.req, " R10 pulse kind"}, {78'd0, done, stack_fault},
              {78'd0, !it.is_fault, it.is_fault});
          chk(top_ptr == it.top, {it.req, " R7 top"}, 80'(top_ptr), 80'(it.top));
          chk(st_value == it.val, {it.req, " R4 value"}, st_value, it.val);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(top_ptr == 3'd0, "R11 top", 80'(top_ptr), 80'd0);
    chk(!done && !stack_fault, "R11 pulses", {78'd0, done, stack_fault}, 80'd0);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #1;
      chk(!st_valid, "R11 tag empty", 80'(st_valid), 80'd0);
    end
    rd_idx = 3'd0;

    // R1 R3 R4: 16-bit +1 with upper garbage ignored
    send(8'hDF, 3'd0, 64'hABCD_1234_5678_0001, "R1 16b +1");
    idle(1);
    idle(1);
    // R10 one-cycle pulse
    chk(!done, "R10 done width", 80'(done), 80'd0);
    chk(st_value == 80'h3FFF_8000_0000_0000_0000, "R4 one", st_value,
        80'h3FFF_8000_0000_0000_0000);

    // R3 negative 16-bit
    send(8'hDF, 3'd0, 64'h0000_7777_0000_FFFF, "R3 16b -1");
    idle(2);
    chk(st_value[79] == 1'b1, "R3 sign", 80'(st_value[79]), 80'd1);

    // R2 unknown encodings ignored
    send(8'hDB, 3'd5, 64'd99, "R2");
    send(8'hD9, 3'd0, 64'd99, "R2");
    idle(3);
    chk(top_ptr == m_top, "R2 top kept", 80'(top_ptr), 80'(m_top));
    chk(st_value == m_val[m_top], "R2 value kept", st_value, m_val[m_top]);

    // R1 32-bit most negative, R5 zero, R6 64-bit minimum
    send(8'hDB, 3'd0, 64'hFFFF_0000_8000_0000, "R1 32b min");
    idle(1);
    send(8'hDF, 3'd5, 64'd0, "R5 zero");
    idle(2);
    chk(st_value == 80'd0, "R5 zero word", st_value, 80'd0);
    send(8'hDF, 3'd5, 64'h8000_0000_0000_0000, "R6 min64");
    idle(2);
    chk(st_value == 80'hC03E_8000_0000_0000_0000, "R6 min64 word", st_value,
        80'hC03E_8000_0000_0000_0000);

    // Back-to-back: fill remaining slots, then one push too many
    send(8'hDF, 3'd5, 64'h7FFF_FFFF_FFFF_FFFF, "R4 max64");
    send(8'hDB, 3'd0, 64'd5, "R1 32b five");
    send(8'hDF, 3'd0, 64'h0000_0000_0000_8000, "R3 16b min");
    send(8'hDF, 3'd5, 64'd12345, "R9 overflow");
    idle(3);
    chk(sb_q.size() == 0, "R9 all results seen", 80'(sb_q.size()), 80'd0);
    chk(top_ptr == 3'd0, "R9 top kept", 80'(top_ptr), 80'd0);
    chk(st_value == m_val[0], "R9 value kept", st_value, m_val[0]);

    // R7 R8 readback of every register relative to top
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #1;
      chk(st_value == m_val[3'(m_top + 3'(i))], "R7 readback", st_value,
          m_val[3'(m_top + 3'(i))]);
      chk(st_valid == m_tag[3'(m_top + 3'(i))], "R8 tag readback",
          80'(st_valid), 80'(m_tag[3'(m_top + 3'(i))]));
    end
    rd_idx = 3'd0;

    // R11 reset mid-run clears the stack
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(top_ptr == 3'd0 && !st_valid, "R11 re-reset", {77'd0, top_ptr},
        80'd0);
    send(8'hDB, 3'd0, 64'hFFFF_FFFF_FFFF_FFFA, "R8 after reset");
    idle(3);
    chk(st_valid, "R8 tag set", 80'(st_valid), 80'd1);
    chk(sb_q.size() == 0, "R10 queue drained", 80'(sb_q.size()), 80'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule